// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards the transmit side of a 10 Mb/s twisted-pair port against a transmitter that never stops. It counts how long the internal transmit-active signal stays high, measured in periodic millisecond ticks. If activity runs past a configurable limit, the block enters the jabber state. In that state it blocks the transmit data path and raises a flag that the collision logic merges into its collision indication. It also sets a sticky status bit.

Link test pulses are generated elsewhere and are merged onto the line output in this block. They are never gated, so the link stays up while data is blocked. The block leaves the jabber state only after the transmit stream has been silent for a full unjab interval. Any renewed activity during that interval restarts the wait. Both limits are parameters counted in ticks: `JAB_LIMIT` defaults to 100 and `UNJAB_TIME` to 500.

Top module: `tx_jabber_guard`

## Requirements
- R1: The jabber state is entered on the `JAB_LIMIT`-th tick that arrives while `tx_active` has stayed high continuously. `jabber_col` then goes high on the clock edge that samples that tick.
- R2: When `tx_active` drops before the limit is reached, the activity count returns to zero. A later burst must again see `JAB_LIMIT` ticks before the jabber state is entered.
- R3: `tx_data_en` is high exactly when the block is not in the jabber state.
- R4: `line_out` equals `(tx_data_in AND tx_data_en) OR link_pulse`. Link pulses reach the line in every state.
- R5: `jabber_col` is high exactly while the jabber state is active.
- R6: `jabber_status` is set on the edge at which the jabber state is entered.
- R7: The unjab count advances only on ticks sampled while `tx_active` is low. Any cycle with `tx_active` high in the jabber state returns the count to zero.
- R8: The jabber state is left on the `UNJAB_TIME`-th idle tick of an uninterrupted idle stretch. That exit releases `jabber_col` and re-enables `tx_data_en`.
- R9: A `status_rd` pulse clears `jabber_status` only when the block is not in the jabber state. Otherwise `jabber_status` stays set.
- R10: A synchronous active-low reset leaves the block out of the jabber state, with `tx_data_en`=1, `jabber_col`=0 and `jabber_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ms_tick | input | 1 | One-cycle timing tick (nominally 1 ms) |
| tx_active | input | 1 | Internal transmit stream active |
| tx_data_in | input | 1 | Encoded transmit data toward the line |
| link_pulse | input | 1 | Link test pulse from the pulse generator |
| status_rd | input | 1 | Status read strobe; clears the sticky bit |
| tx_data_en | output | 1 | Transmit data path enable |
| line_out | output | 1 | Gated data merged with link pulses |
| jabber_col | output | 1 | Jabber active, to the collision logic |
| jabber_status | output | 1 | Sticky jabber-detect status |

## Verification
The hardest case to reach from the ports is the restarted unjab wait. The block must already be jabbering, and transmit activity must resume just before the idle interval would have expired. Release must then take a full fresh interval. Directed sequences cover this case, along with a burst that stops one tick short of the limit. Randomly driven long transmit bursts also reach the jabber state many times, and a cycle-accurate reference model in the bench checks every output on every cycle.

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
  parameter int JAB_LIMIT  = 100,
  parameter int UNJAB_TIME = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic tx_active,
  input  logic tx_data_in,
  input  logic link_pulse,
  input  logic status_rd,
  output logic tx_data_en,
  output logic line_out,
  output logic jabber_col,
  output logic jabber_status
);
  localparam int TW = $clog2(JAB_LIMIT + 1);
  localparam int UW = $clog2(UNJAB_TIME + 1);

  logic          jab_q;
  logic          sts_q;
  logic [TW-1:0] act_cnt;
  logic [UW-1:0] idle_cnt;
  logic          act_hit;
  logic          idle_hit;

  assign act_hit  = ms_tick && tx_active && (act_cnt == TW'(JAB_LIMIT - 1));
  assign idle_hit = ms_tick && !tx_active && (idle_cnt == UW'(UNJAB_TIME - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jab_q    <= 1'b0;
      act_cnt  <= '0;
      idle_cnt <= '0;
    end else if (!jab_q) begin
      idle_cnt <= '0;
      if (!tx_active) act_cnt <= '0;
      else if (act_hit) begin
        jab_q   <= 1'b1;
        act_cnt <= '0;
      end else if (ms_tick) act_cnt <= act_cnt + 1'b1;
    end else begin
      act_cnt <= '0;
      if (tx_active) idle_cnt <= '0;
      else if (idle_hit) begin
        jab_q    <= 1'b0;
        idle_cnt <= '0;
      end else if (ms_tick) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= 1'b0;
    else if (!jab_q && act_hit) sts_q <= 1'b1;
    else if (status_rd && !jab_q) sts_q <= 1'b0;
  end

  assign tx_data_en    = !jab_q;
  assign jabber_col    = jab_q;
  assign jabber_status = sts_q;
  assign line_out      = (tx_data_in && tx_data_en) || link_pulse;
endmodule

// File: rtl/tx_jabber_guard_chk.sv
module tx_jabber_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic tx_active,
  input logic tx_data_in,
  input logic link_pulse,
  input logic status_rd,
  input logic tx_data_en,
  input logic line_out,
  input logic jabber_col,
  input logic jabber_status
);
  AST_JAB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jabber_col) |-> $past(ms_tick) && $past(tx_active)); // R1
  AST_LINK_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    link_pulse |-> line_out); // R4
  AST_DATA_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (jabber_col && !link_pulse) |-> !line_out); // R3
  AST_STATUS_WHILE_JAB: assert property (@(posedge clk) disable iff (!rst_n)
    jabber_col |-> jabber_status); // R6
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jabber_col) |-> $past(ms_tick) && !$past(tx_active)); // R8
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (jabber_col && status_rd) |=> jabber_status); // R9
endmodule

bind tx_jabber_guard tx_jabber_guard_chk chk_i (.*);

// File: tb/tx_jabber_guard_tb_top.sv
module tx_jabber_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 5;
  localparam int UNJ = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, tx_active = 1'b0, tx_data_in = 1'b0;
  logic link_pulse = 1'b0, status_rd = 1'b0;
  logic tx_data_en, line_out, jabber_col, jabber_status;

  int checks = 0;
  int errors = 0;
  int m_tc = 0, m_uc = 0;
  bit m_jab = 0, m_sts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_jabber_guard #(.JAB_LIMIT(LIM), .UNJAB_TIME(UNJ)) dut_i (.*);

  function automatic bit exp_line(bit d, bit lp, bit jab);
    return (d && !jab) || lp;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit old_jab;
    old_jab = m_jab;
    if (!rst_n) begin
      m_jab = 0; m_sts = 0; m_tc = 0; m_uc = 0;
    end else begin
      if (!m_jab) begin
        m_uc = 0;
        if (!tx_active) m_tc = 0;
        else if (ms_tick) begin
          if (m_tc == LIM - 1) begin m_jab = 1; m_tc = 0; end
          else m_tc++;
        end
      end else begin
        m_tc = 0;
        if (tx_active) m_uc = 0;
        else if (ms_tick) begin
          if (m_uc == UNJ - 1) begin m_jab = 0; m_uc = 0; end
          else m_uc++;
        end
      end
      if (!old_jab && m_jab) m_sts = 1;
      else if (status_rd && !old_jab) m_sts = 0;
    end
    #2;
    chk("R3 tx_data_en", tx_data_en, !m_jab);
    chk("R5/R1/R8 jabber_col", jabber_col, m_jab);
    chk("R6/R9 jabber_status", jabber_status, m_sts);
    chk("R4 line_out", line_out, exp_line(tx_data_in, link_pulse, m_jab));
  end

  task automatic ticks(int n, bit act);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_active = act; ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset en", tx_data_en, 1'b1);
    chk("R10 reset col", jabber_col, 1'b0);
    chk("R10 reset sts", jabber_status, 1'b0);
    // R2: burst one tick short, gap, again short
    ticks(LIM - 1, 1'b1);
    @(negedge clk); tx_active = 1'b0;
    @(negedge clk);
    ticks(LIM - 1, 1'b1);
    chk("R2 no jab after split burst", jabber_col, 1'b0);
    ticks(1, 1'b1);
    chk("R1 jab at limit", jabber_col, 1'b1);
    @(negedge clk); status_rd = 1'b1; link_pulse = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk("R9 read during jab keeps status", jabber_status, 1'b1);
    chk("R4 link pulse while jab", line_out, 1'b1);
    link_pulse = 1'b0;
    // R7: idle almost to the end, then resume
    ticks(UNJ - 1, 1'b0);
    chk("R7 still jab before end", jabber_col, 1'b1);
    @(negedge clk); tx_active = 1'b1;
    @(negedge clk); tx_active = 1'b0;
    ticks(UNJ - 1, 1'b0);
    chk("R7 restart holds jab", jabber_col, 1'b1);
    ticks(1, 1'b0);
    chk("R8 released", tx_data_en, 1'b1);
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk("R9 read clears status", jabber_status, 1'b0);
    // random phase
    for (int c = 0; c < 30000; c++) begin
      @(negedge clk);
      ms_tick    = ($urandom % 4) == 0;
      if (($urandom % 60) == 0) tx_active = !tx_active;
      tx_data_in = $urandom % 2;
      link_pulse = ($urandom % 8) == 0;
      status_rd  = ($urandom % 16) == 0;
      if (c == 15000) rst_n = 1'b0;
      if (c == 15003) rst_n = 1'b1;
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule